// File: doc/BRIEF.md
# SPI Command Port for a Byte UART

This block is the peripheral-facing front end of a UART that a host reaches over SPI. Each SPI frame is a single 16-bit full-duplex word, most significant bit first, using clock mode 0 (data sampled on the rising SCLK edge and changed on the falling edge). The two leading bits of the host word form an opcode that selects one of four operations: configuration write, configuration read, character write, or character read. Each reply word opens with two status flags, receive-data-available and transmit-empty.

The block stores the 14-bit line configuration and drives it to the UART core. It buffers received characters in a 16-entry FIFO and holds one outgoing character for the core. The core pushes received characters with a one-cycle strobe. It takes the outgoing character through a valid/ready pair. The SPI pins are oversampled in the system clock domain, and every state change happens on that clock.

Top module: `spiCharPort`

## Requirements
- R1: A frame begins when csN falls and is decoded on its 16th rising SCLK edge. If csN rises before the 16th edge, the frame is abandoned: the FIFO, configuration, transmit holder, RTS and overrun flag all keep their values.
- R2: Command bit 15 selects write (1) or read (0). Command bit 14 selects configuration (1) or data (0).
- R3: Reply bit 15 is receive-data-available (FIFO not empty) and reply bit 14 is transmit-empty (holder free). Both are sampled when csN falls and are present in the reply to every opcode.
- R4: A configuration write loads command bits 13:0 into cfgOut. A configuration read returns cfgOut in reply bits 13:0. Every other opcode except a data read returns zero in reply bits 13:0.
- R5: A configuration write empties the receive FIFO and clears the transmit overrun flag.
- R6: A data-read reply places the frame-error flag in bit 10, the CTS level in bit 9, the ninth bit in bit 8 and the character in bits 7:0, with bits 13:11 zero. An entry is removed only if bit 15 of that same reply was 1. When the FIFO is empty, bits 10, 8 and 7:0 read as zero.
- R7: The FIFO holds 16 entries and returns them in arrival order. A character pushed while the FIFO is full is discarded.
- R8: A data write with bit 10 clear loads bits 7:0 into txChar and bit 8 into txNinth, and raises txValid, if the holder is free when the frame is decoded.
- R9: A data write with bit 10 clear that arrives while txValid is high is discarded and sets txOverrun. txOverrun stays set until the next configuration write.
- R10: Every data write copies its bit 9 to rtsOut, whatever the value of bit 10. A data write with bit 10 set sends no character.
- R11: When cfgOut bit 4 (seven-bit words) is set, bit 7 of a stored received character and of a loaded transmit character is forced to 0.
- R12: txValid stays high until a clock where txReady is high. After that the holder is free and transmit-empty reads 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host (0 when not selected) |
| cfgOut | output | 14 | Configuration register to the UART core |
| rtsOut | output | 1 | RTS level requested by the host |
| ctsIn | input | 1 | CTS level from the line |
| txValid | output | 1 | Transmit character pending |
| txChar | output | 8 | Transmit character |
| txNinth | output | 1 | Transmit parity/ninth bit |
| txReady | input | 1 | UART core takes the pending character |
| txOverrun | output | 1 | Sticky flag: a data write was discarded |
| rxValid | input | 1 | UART core delivers a received character |
| rxChar | input | 8 | Received character |
| rxNinth | input | 1 | Received parity/ninth bit |
| rxFrameErr | input | 1 | Received character had a framing error |

## Verification
The embedded properties check on every cycle that a push into a full FIFO leaves the count unchanged and that a configuration write leaves the FIFO empty. They also check that a character write into a busy holder raises the overrun flag, that a read without the available flag pops nothing, and that the reply status bits equal the FIFO and holder state at frame start. The bench scenarios cover the rest: reply field placement per opcode, arrival order through a full FIFO, the effect of an abandoned frame, seven-bit masking, RTS updates from writes that send no character, and the transmit handshake.

// File: rtl/spiCharPkg.sv
package spiCharPkg;
  localparam int WORD_W = 16;
  localparam int CFG_W  = 14;
  localparam int CHAR_W = 8;

  // command / reply bit positions
  localparam int B_WRITE  = 15;
  localparam int B_CONFIG = 14;
  localparam int B_NOSEND = 10;
  localparam int B_FRERR  = 10;
  localparam int B_RTS    = 9;
  localparam int B_CTS    = 9;
  localparam int B_NINTH  = 8;
  localparam int C_SEVEN  = 4;

  typedef struct packed {
    logic             snap;     // frame start: capture status
    logic             wrCfg;
    logic             wrData;
    logic             rdData;
    logic [1:0]       respSel;  // opcode latched after 2nd bit
    logic [CFG_W-1:0] payload;
  } cmdStrobe_t;
endpackage

// File: rtl/spiCharFifo.sv
module spiCharFifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> (count == $past(count))) else $error("full push changed count"); // R7
endmodule

// File: rtl/spiCharCtrl.sv
module spiCharCtrl
  import spiCharPkg::*;
#(
  parameter int FRAME_BITS = WORD_W,
  localparam int BCW = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  input  logic [WORD_W-1:0] respWord,
  output logic              miso,
  output cmdStrobe_t        strb
);
  logic [2:0] sclkSync;
  logic [1:0] csSync, mosiSync;
  logic csActive, csActPrev, sclkRise, sclkFall, bitIn;
  logic [BCW-1:0] bitCnt, outPtr;
  logic [FRAME_BITS-2:0] rxShift;
  logic [1:0] opSel;
  logic frameDone;
  logic [FRAME_BITS-1:0] word;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  assign csActive  = !csSync[1];
  assign sclkRise  = sclkSync[1] && !sclkSync[2];
  assign sclkFall  = !sclkSync[1] && sclkSync[2];
  assign bitIn     = mosiSync[1];
  assign frameDone = csActive && sclkRise && (bitCnt == BCW'(FRAME_BITS - 1));
  assign word      = {rxShift, bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csActPrev <= 1'b0;
      bitCnt    <= '0;
      outPtr    <= '0;
      rxShift   <= '0;
      opSel     <= 2'b10;
    end else begin
      csActPrev <= csActive;
      if (!csActive) begin
        bitCnt <= '0;
        outPtr <= '0;
      end else if (!csActPrev) begin
        bitCnt <= '0;
        outPtr <= '0;
        opSel  <= 2'b10;
      end else begin
        if (sclkRise && bitCnt < BCW'(FRAME_BITS)) begin
          rxShift <= {rxShift[FRAME_BITS-3:0], bitIn};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == BCW'(1)) opSel <= {rxShift[0], bitIn};
        end
        if (sclkFall && bitCnt < BCW'(FRAME_BITS)) outPtr <= bitCnt;
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.snap    = csActive && !csActPrev;
    strb.respSel = opSel;
    strb.payload = word[CFG_W-1:0];
    if (frameDone) begin
      strb.wrCfg  =  word[B_WRITE] &&  word[B_CONFIG];
      strb.wrData =  word[B_WRITE] && !word[B_CONFIG];
      strb.rdData = !word[B_WRITE] && !word[B_CONFIG];
    end
  end

  always_comb begin
    miso = 1'b0;
    if (csActive && outPtr < BCW'(FRAME_BITS))
      miso = respWord[4'(FRAME_BITS - 1 - int'(outPtr))];
  end

  AST_ABORT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive) |=> (bitCnt == '0)) else $error("frame count survived deselect"); // R1
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCfg, strb.wrData, strb.rdData})) else $error("multiple ops"); // R2
endmodule

// File: rtl/spiCharData.sv
module spiCharData
  import spiCharPkg::*;
#(
  parameter int RX_DEPTH = 16,
  localparam int ENT_W = CHAR_W + 2,
  localparam int CW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strb,
  output logic [WORD_W-1:0] respWord,
  output logic [CFG_W-1:0]  cfgOut,
  output logic              rtsOut,
  input  logic              ctsIn,
  output logic              txValid,
  output logic [CHAR_W-1:0] txChar,
  output logic              txNinth,
  input  logic              txReady,
  output logic              txOverrun,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxNinth,
  input  logic              rxFrameErr
);
  logic [1:0] ctsSync;
  logic seven;
  logic [ENT_W-1:0] pushEnt, headEnt;
  logic [CW-1:0] fifoCount;
  logic fifoEmpty, fifoFull, popReq;
  logic snapR, snapT, snapCts;
  logic [ENT_W-1:0] snapEnt;
  logic [CHAR_W-1:0] charMask;

  assign seven    = cfgOut[C_SEVEN];
  assign charMask = seven ? CHAR_W'({(CHAR_W-1){1'b1}}) : '1;
  assign pushEnt  = {rxFrameErr, rxNinth, rxChar & charMask};
  assign popReq   = strb.rdData && snapR;

  spiCharFifo #(.WIDTH(ENT_W), .DEPTH(RX_DEPTH)) i_rxFifo (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strb.wrCfg),
    .push  (rxValid),
    .din   (pushEnt),
    .pop   (popReq),
    .dout  (headEnt),
    .count (fifoCount),
    .empty (fifoEmpty),
    .full  (fifoFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctsSync <= '0;
    else       ctsSync <= {ctsSync[0], ctsIn};
  end

  // status captured at frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapR   <= 1'b0;
      snapT   <= 1'b1;
      snapCts <= 1'b0;
      snapEnt <= '0;
    end else if (strb.snap) begin
      snapR   <= !fifoEmpty;
      snapT   <= !txValid;
      snapCts <= ctsSync[1];
      snapEnt <= fifoEmpty ? '0 : headEnt;
    end
  end

  always_comb begin
    respWord = '0;
    respWord[B_WRITE]  = snapR;
    respWord[B_CONFIG] = snapT;
    unique case (strb.respSel)
      2'b00: begin
        respWord[B_FRERR]         = snapEnt[ENT_W-1];
        respWord[B_CTS]           = snapCts;
        respWord[B_NINTH]         = snapEnt[CHAR_W];
        respWord[CHAR_W-1:0]      = snapEnt[CHAR_W-1:0];
      end
      2'b01:   respWord[CFG_W-1:0] = cfgOut;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgOut    <= '0;
      rtsOut    <= 1'b0;
      txValid   <= 1'b0;
      txChar    <= '0;
      txNinth   <= 1'b0;
      txOverrun <= 1'b0;
    end else begin
      if (txValid && txReady) txValid <= 1'b0;
      if (strb.wrCfg) begin
        cfgOut    <= strb.payload;
        txOverrun <= 1'b0;
      end
      if (strb.wrData) begin
        rtsOut <= strb.payload[B_RTS];
        if (!strb.payload[B_NOSEND]) begin
          if (!txValid) begin
            txValid <= 1'b1;
            txChar  <= strb.payload[CHAR_W-1:0] & charMask;
            txNinth <= strb.payload[B_NINTH];
          end else begin
            txOverrun <= 1'b1;
          end
        end
      end
    end
  end

  AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCfg |=> (fifoCount == '0)) else $error("fifo not cleared"); // R5
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && !strb.payload[B_NOSEND] && txValid && !txReady) |=> (txOverrun && $stable(txChar))) else $error("busy write not dropped"); // R9
  AST_POP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdData && !snapR && !rxValid && !strb.wrCfg) |=> $stable(fifoCount)) else $error("pop without ready flag"); // R6
  AST_STATUS_SNAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap |=> (respWord[B_WRITE] == $past(!fifoEmpty) && respWord[B_CONFIG] == $past(!txValid))) else $error("status snapshot"); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid) else $error("tx dropped without ready"); // R12
endmodule

// File: rtl/spiCharPort.sv
module spiCharPort
  import spiCharPkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic [CFG_W-1:0]  cfgOut,
  output logic              rtsOut,
  input  logic              ctsIn,
  output logic              txValid,
  output logic [CHAR_W-1:0] txChar,
  output logic              txNinth,
  input  logic              txReady,
  output logic              txOverrun,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxNinth,
  input  logic              rxFrameErr
);
  cmdStrobe_t strb;
  logic [WORD_W-1:0] respWord;

  spiCharCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .respWord(respWord), .miso(miso), .strb(strb)
  );

  spiCharData #(.RX_DEPTH(RX_DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .respWord(respWord),
    .cfgOut(cfgOut), .rtsOut(rtsOut), .ctsIn(ctsIn),
    .txValid(txValid), .txChar(txChar), .txNinth(txNinth),
    .txReady(txReady), .txOverrun(txOverrun),
    .rxValid(rxValid), .rxChar(rxChar), .rxNinth(rxNinth),
    .rxFrameErr(rxFrameErr)
  );
endmodule

// File: tb/test_spiCharPort.sv
module test_spiCharPort;
  logic clk = 0, rstN = 0;
  logic sclk = 0, csN = 1, mosi = 0, miso;
  logic [13:0] cfgOut;
  logic rtsOut, ctsIn = 1, txValid, txNinth, txReady = 0, txOverrun;
  logic [7:0] txChar, rxChar = 0;
  logic rxValid = 0, rxNinth = 0, rxFrameErr = 0;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] r;

  always #2 clk = ~clk;

  spiCharPort i_spiCharPort (.*);

  // {command, expected reply}
  localparam logic [31:0] VEC [6] = '{
    {16'h4000, 16'h4000},   // read cfg at reset
    {16'hE00B, 16'h4000},   // write cfg
    {16'h4000, 16'h600B},   // read cfg back
    {16'h0000, 16'h4200},   // read data, empty, cts=1
    {16'h8600, 16'h4000},   // write data, no send, rts=1
    {16'h8400, 16'h4000}    // rts back to 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spiXfer(input logic [15:0] cmd, output logic [15:0] resp, input int nbits = 16);
    resp = '0;
    @(negedge clk) csN = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = cmd[15-i];
      repeat (4) @(negedge clk);
      resp[15-i] = miso;
      sclk = 1;
      repeat (8) @(negedge clk);
      sclk = 0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    csN = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rxPush(input logic [7:0] c, input logic n, input logic fe);
    @(negedge clk);
    rxValid = 1; rxChar = c; rxNinth = n; rxFrameErr = fe;
    @(negedge clk);
    rxValid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);
    // reset state
    chk("R8 reset txValid", txValid, 0);
    chk("R10 reset rts", rtsOut, 0);
    chk("R4 reset cfg", cfgOut, 0);
    chk("R9 reset overrun", txOverrun, 0);

    foreach (VEC[k]) begin
      spiXfer(VEC[k][31:16], r);
      chk($sformatf("R2/R3/R4 vector %0d", k), r, VEC[k][15:0]);
    end
    chk("R4 cfgOut", cfgOut, 14'h200B);
    chk("R10 rts low after write", rtsOut, 0);
    chk("R10 no send", txValid, 0);

    // R6 read layout and order
    rxPush(8'h11, 0, 0);
    rxPush(8'h22, 1, 0);
    rxPush(8'h33, 0, 1);
    spiXfer(16'h0000, r); chk("R6 first", r, 16'hC211);
    spiXfer(16'h0000, r); chk("R6 ninth", r, 16'hC322);
    spiXfer(16'h0000, r); chk("R6 frame err", r, 16'hC633);
    spiXfer(16'h0000, r); chk("R6 empty", r, 16'h4200);

    // R1 aborted frames
    rxPush(8'h44, 0, 0);
    spiXfer(16'h0000, r, 8);
    spiXfer(16'hE0FF, r, 8);
    chk("R1 cfg kept", cfgOut, 14'h200B);
    spiXfer(16'h0000, r); chk("R1 entry kept", r, 16'hC244);
    spiXfer(16'h0000, r); chk("R1 single entry", r, 16'h4200);

    // R7 full fifo
    for (int i = 0; i < 17; i++) rxPush(8'(i + 8'h50), 0, 0);
    for (int i = 0; i < 16; i++) begin
      spiXfer(16'h0000, r);
      chk("R7 order", r, 16'hC200 | 16'(i + 8'h50));
    end
    spiXfer(16'h0000, r); chk("R7 overflow dropped", r, 16'h4200);

    // R8 transmit
    spiXfer(16'h8155, r);
    chk("R8 txValid", txValid, 1);
    chk("R8 txChar", txChar, 8'h55);
    chk("R8 txNinth", txNinth, 1);
    spiXfer(16'h0000, r); chk("R3 T clear", r, 16'h0200);
    // R9 overrun
    spiXfer(16'h8066, r);
    chk("R9 overrun set", txOverrun, 1);
    chk("R9 char kept", txChar, 8'h55);
    // R12 handshake
    @(negedge clk) txReady = 1;
    @(negedge clk) txReady = 0;
    @(negedge clk);
    chk("R12 released", txValid, 0);
    spiXfer(16'h0000, r); chk("R12 T back", r, 16'h4200);
    chk("R9 overrun sticky", txOverrun, 1);

    // R5 config write flushes
    rxPush(8'h77, 0, 0);
    rxPush(8'h78, 0, 0);
    spiXfer(16'hE01B, r);
    chk("R5 overrun cleared", txOverrun, 0);
    spiXfer(16'h0000, r); chk("R5 fifo empty", r, 16'h4200);

    // R11 seven-bit mode
    rxPush(8'hC5, 0, 0);
    spiXfer(16'h0000, r); chk("R11 rx mask", r, 16'hC245);
    spiXfer(16'h80F3, r); chk("R11 tx mask", txChar, 8'h73);

    // R6 cts low
    ctsIn = 0;
    repeat (4) @(negedge clk);
    spiXfer(16'h0000, r); chk("R6 cts low", r, 16'h0000);
    spiXfer(16'h8600, r); chk("R10 rts with busy holder", rtsOut, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule